// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Sequencer

This block runs a serial successive-approximation converter. It pulses an active-low convert strobe and then waits for the converter's end-of-conversion line to fall. After that it reads the 16-bit result word over a three-wire link made of chip select, serial clock and serial data in. The word holds a 14-bit result followed by two sub-LSB bits. The read takes place in the acquisition window between conversions. After the last bit, a programmable quiet gap runs before the next strobe, so that noise coupled from the serial clock can settle on the analog input.

A conversion can be requested one at a time with a start pulse. In continuous mode each completed read-and-settle sequence launches the next strobe with no request, so conversions follow each other with no idle time. Three serial clock modes set the idle level and the sampling edge. The mode is latched when each conversion starts. The sample leaves the block on a plain valid pulse with no back-pressure: the consumer must take the word in the cycle in which `sample_valid` is high. There is no ready input, because the converter cannot be stalled once it has been started.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `adc_conv_n` and `adc_cs_n` are high, `adc_sclk` is low, and `busy` and `sample_valid` are low.
- R2: A start request accepted in idle drives `adc_conv_n` low for exactly CONV_PULSE_CYCLES system clock cycles. `busy` goes high on the same edge.
- R3: A readout begins only on a falling edge of the synchronised end-of-conversion line that occurs while the block waits for one. Edges at any other time start no readout, and chip select stays high.
- R4: Each readout shifts 16 bits, most significant first. Frame bits 15..2 appear on `sample_result` (B13 first) and frame bits 1..0 on `sample_sub` (S1 then S0).
- R5: Encodings of `sclk_mode`: 0 means the clock idles low and data is sampled on the rising edge. 1 means it idles low and data is sampled on the falling edge. 2 means it idles high and data is sampled on the falling edge. 3 behaves as 0. Each frame has exactly 16 sampling edges.
- R6: Chip select falls before the first serial clock edge and rises after the last one. While chip select is high, the serial clock rests at the idle level of the active mode, and the convert strobe is never low while chip select is low.
- R7: `sample_valid` is a one-cycle pulse on the same edge on which chip select rises. The sample outputs hold their value until the next frame.
- R8: From the rise of chip select to the next fall of the convert strobe, at least SETTLE_CYCLES cycles pass. In continuous mode it is exactly SETTLE_CYCLES.
- R9: With `continuous_en` high, conversions repeat with no start request. When it is cleared, no new strobe is issued after the current sequence ends.
- R10: A start request while `busy` is high is ignored. `busy` stays high until the settle gap ends.
- R11: Every serial clock half-period lasts exactly SCLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Single-shot conversion request, sampled in idle |
| continuous_en | input | 1 | Run conversions back to back |
| sclk_mode | input | 2 | Serial clock idle level and sampling edge select |
| busy | output | 1 | Sequence in progress |
| adc_conv_n | output | 1 | Active-low convert strobe to the converter |
| adc_eoc_n | input | 1 | End-of-conversion line from the converter, asynchronous |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock |
| adc_sdata | input | 1 | Serial data from the converter |
| sample_result | output | 14 | Conversion result B13..B0 |
| sample_sub | output | 2 | Sub-LSB bits S1..S0 |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench models the converter for each clock mode. It presents each bit on the edge opposite the sampling edge, so if the sampling edge were wrong the word would come out shifted by one bit. The model also counts sampling edges and half-period lengths, which would expose a frame with 15 or 17 clocks or a divider that is off by one. Directed runs fire an end-of-conversion edge while the block is idle and a start request during readout and during settle. A design that failed to ignore these would drop chip select or issue an extra strobe. The gap from chip select rising to the next strobe is counted to the cycle in continuous mode, and the bench applies a reset in the middle of a frame.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_EOC,
    ST_CS_SETUP,
    ST_SHIFT,
    ST_CS_HOLD,
    ST_SETTLE
  } ctrl_state_e;

  // serial clock configuration latched per conversion
  typedef struct packed {
    logic cpol;         // idle level of the serial clock
    logic late_sample;  // sample on the return-to-idle edge
  } sclk_cfg_t;

  function automatic sclk_cfg_t decode_sclk_mode(input logic [1:0] mode);
    sclk_cfg_t cfg;
    case (mode)
      2'd1:    cfg = '{cpol: 1'b0, late_sample: 1'b1};
      2'd2:    cfg = '{cpol: 1'b1, late_sample: 1'b0};
      default: cfg = '{cpol: 1'b0, late_sample: 1'b0};
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_n_async,
  output logic eoc_fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= eoc_n_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign eoc_fall = prev_q & ~sync_q;

  // R3: a synchronised falling edge never lasts two cycles
  assert_eoc_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_fall |=> !eoc_fall);

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpol_next,
  output logic rise_ev,
  output logic fall_ev,
  output logic sclk
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] div_q;
  logic             phase_q;
  logic             phase_d;
  logic             tick;

  assign tick    = run && (div_q == CNT_W'(HALF_DIV - 1));
  assign rise_ev = tick & ~phase_q;
  assign fall_ev = tick & phase_q;

  always_comb begin
    if (!run)      phase_d = 1'b0;
    else if (tick) phase_d = ~phase_q;
    else           phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      sclk    <= 1'b0;
    end else begin
      if (!run || tick) div_q <= '0;
      else              div_q <= div_q + 1'b1;
      phase_q <= phase_d;
      sclk    <= phase_d ^ cpol_next;
    end
  end

  // R11: the phase toggles only after a full divider count
  assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (phase_q != $past(phase_q))) |-> $past(tick));

  assert_edge_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rise_ev, fall_ev}) <= 1);

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word <= '0;
    else if (sample_en) word <= {word[WIDTH-2:0], din};
  end
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_BITS          = 14,
  parameter int unsigned SUB_BITS          = 2,
  parameter int unsigned SCLK_DIV          = 5,
  parameter int unsigned CONV_PULSE_CYCLES = 2,
  parameter int unsigned SETTLE_CYCLES     = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                continuous_en,
  input  logic [1:0]          sclk_mode,
  output logic                busy,
  output logic                adc_conv_n,
  input  logic                adc_eoc_n,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  input  logic                adc_sdata,
  output logic [RES_BITS-1:0] sample_result,
  output logic [SUB_BITS-1:0] sample_sub,
  output logic                sample_valid
);
  localparam int unsigned FRAME_BITS = RES_BITS + SUB_BITS;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned TMR_MAX    = (CONV_PULSE_CYCLES > SETTLE_CYCLES) ?
                                       CONV_PULSE_CYCLES : SETTLE_CYCLES;
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);

  ctrl_state_e           state_q, state_d;
  logic [TMR_W-1:0]      tmr_q;
  logic [BIT_W-1:0]      bit_q;
  sclk_cfg_t             cfg_q, cfg_d;
  logic                  eoc_fall;
  logic                  rise_ev, fall_ev, sample_en, last_fall;
  logic [FRAME_BITS-1:0] frame_word;

  adc_eoc_sync u_eoc (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoc_n_async (adc_eoc_n),
    .eoc_fall    (eoc_fall)
  );

  adc_sclk_gen #(.HALF_DIV(SCLK_DIV)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state_q == ST_SHIFT),
    .cpol_next (cfg_d.cpol),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .sclk      (adc_sclk)
  );

  assign sample_en = cfg_q.late_sample ? fall_ev : rise_ev;
  assign last_fall = fall_ev && (bit_q == BIT_W'(FRAME_BITS - 1));

  adc_rx_shift #(.WIDTH(FRAME_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .din       (adc_sdata),
    .word      (frame_word)
  );

  // sequencing
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_req || continuous_en) state_d = ST_CONV;
      ST_CONV:     if (tmr_q == TMR_W'(CONV_PULSE_CYCLES - 1)) state_d = ST_WAIT_EOC;
      ST_WAIT_EOC: if (eoc_fall) state_d = ST_CS_SETUP;
      ST_CS_SETUP: state_d = ST_SHIFT;
      ST_SHIFT:    if (last_fall) state_d = ST_CS_HOLD;
      ST_CS_HOLD:  state_d = ST_SETTLE;
      ST_SETTLE:   if (tmr_q == TMR_W'(SETTLE_CYCLES - 1))
                     state_d = continuous_en ? ST_CONV : ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // clock mode is latched on entry to each conversion
  always_comb begin
    cfg_d = cfg_q;
    if (state_d == ST_CONV && state_q != ST_CONV) cfg_d = decode_sclk_mode(sclk_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      bit_q      <= '0;
      cfg_q      <= '0;
      adc_conv_n <= 1'b1;
      adc_cs_n   <= 1'b1;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      if (state_d != state_q)                           tmr_q <= '0;
      else if (state_q == ST_CONV || state_q == ST_SETTLE) tmr_q <= tmr_q + 1'b1;
      if (state_q == ST_CS_SETUP) bit_q <= '0;
      else if (fall_ev)           bit_q <= bit_q + 1'b1;
      adc_conv_n <= (state_d != ST_CONV);
      adc_cs_n   <= !(state_d == ST_CS_SETUP || state_d == ST_SHIFT || state_d == ST_CS_HOLD);
    end
  end

  // sample presentation, one cycle after the last bit lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_result <= '0;
      sample_sub    <= '0;
      sample_valid  <= 1'b0;
    end else begin
      sample_valid <= (state_q == ST_CS_HOLD);
      if (state_q == ST_CS_HOLD) begin
        sample_result <= frame_word[FRAME_BITS-1:SUB_BITS];
        sample_sub    <= frame_word[SUB_BITS-1:0];
      end
    end
  end

  assign busy = (state_q != ST_IDLE);

  assert_no_strobe_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> adc_conv_n);

  assert_sclk_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> (adc_sclk == cfg_q.cpol));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_valid_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> sample_valid);

  assert_quiet_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_conv_n);

  assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_cs_n && adc_conv_n));

  assert_bit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bit_q < BIT_W'(FRAME_BITS)));

endmodule

// File: tb/tb_adc_serial_ctrl.sv
module tb_adc_serial_ctrl;
  localparam int DIV = 2, CP = 3, ST = 20, CONV_T = 30;

  // {sclk_mode, frame word}
  localparam logic [17:0] VEC [7] = '{
    {2'd0, 16'hA5C3}, {2'd1, 16'h3FFD}, {2'd2, 16'h8001}, {2'd0, 16'hFFFF},
    {2'd1, 16'h0000}, {2'd2, 16'h5A96}, {2'd3, 16'h1234}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_req, continuous_en, adc_eoc_n, adc_sdata;
  logic [1:0] sclk_mode;
  logic busy, adc_conv_n, adc_cs_n, adc_sclk, sample_valid;
  logic [13:0] sample_result;
  logic [1:0]  sample_sub;

  adc_serial_ctrl #(.SCLK_DIV(DIV), .CONV_PULSE_CYCLES(CP), .SETTLE_CYCLES(ST)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .continuous_en(continuous_en),
    .sclk_mode(sclk_mode), .busy(busy), .adc_conv_n(adc_conv_n), .adc_eoc_n(adc_eoc_n),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
    .sample_result(sample_result), .sample_sub(sample_sub), .sample_valid(sample_valid)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_edge = -1, idx = 0, samp_edges = 0, hp_bad = 0;
  int conv_low = 0, conv_falls = 0, cs_falls = 0;
  logic [15:0] adc_word = 16'h0;
  logic [1:0]  mdl_mode = 2'd0;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model
  always @(posedge clk) cyc++;
  always begin
    @(negedge adc_conv_n);
    adc_eoc_n = 1'b1;
    repeat (CONV_T) @(negedge clk);
    adc_eoc_n = 1'b0;
  end
  always @(negedge adc_conv_n) begin conv_low = 0; conv_falls++; end
  always @(negedge clk) if (!adc_conv_n) conv_low++;
  always @(negedge adc_cs_n) begin
    cs_falls++; idx = 0; samp_edges = 0; hp_bad = 0; last_edge = -1;
    if (mdl_mode != 2'd1) begin adc_sdata = adc_word[15]; idx = 1; end
  end
  always @(adc_sclk) if (!adc_cs_n) begin
    if (last_edge >= 0 && (cyc - last_edge) != DIV) hp_bad++;
    last_edge = cyc;
    if ((mdl_mode == 2'd1 || mdl_mode == 2'd2) ? adc_sclk : !adc_sclk) begin
      if (idx < 16) adc_sdata = adc_word[15 - idx];
      idx++;
    end else samp_edges++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!sample_valid);
  endtask

  task automatic run_single(input logic [1:0] m, input logic [15:0] w);
    int prev;
    mdl_mode = m; adc_word = w; sclk_mode = m; prev = conv_falls;
    pulse_start();
    check("R2", "busy after start", busy, 1);
    wait_valid();
    check("R4", "result", sample_result, w[15:2]);
    check("R4", "sub bits", sample_sub, w[1:0]);
    check("R5", "sampling edges", samp_edges, 16);
    check("R11", "bad half periods", hp_bad, 0);
    check("R2", "strobe width", conv_low, CP);
    while (busy) @(negedge clk);
    check("R10", "strobes per request", conv_falls - prev, 1);
    check("R5", "idle sclk level", adc_sclk, (m == 2'd2));
    check("R7", "result held", sample_result, w[15:2]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, prev;
    rst_n = 1'b0; start_req = 1'b0; continuous_en = 1'b0; sclk_mode = 2'd0;
    adc_eoc_n = 1'b1; adc_sdata = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "conv_n in reset", adc_conv_n, 1);
    check("R1", "cs_n in reset", adc_cs_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outputs after reset", {adc_conv_n, adc_cs_n, adc_sclk, busy, sample_valid}, 5'b11000);

    // table walk: R4 R5 R11 R2 R10
    for (int i = 0; i < 7; i++) run_single(VEC[i][17:16], VEC[i][15:0]);

    // R3: end-of-conversion edge while idle
    prev = cs_falls;
    @(negedge clk) adc_eoc_n = 1'b1;
    repeat (5) @(negedge clk);
    adc_eoc_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R3", "cs falls on idle eoc edge", cs_falls - prev, 0);
    check("R3", "busy on idle eoc edge", busy, 0);

    // R10: starts during readout and settle ignored
    mdl_mode = 2'd0; adc_word = 16'hC0DE; sclk_mode = 2'd0; prev = conv_falls;
    pulse_start();
    @(negedge adc_cs_n);
    pulse_start();
    wait_valid();
    check("R10", "result with ignored start", sample_result, 14'(16'hC0DE >> 2));
    pulse_start();
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R10", "strobes after busy starts", conv_falls - prev, 1);
    check("R10", "busy after ignored starts", busy, 0);

    // R8 R9: continuous operation
    mdl_mode = 2'd1; sclk_mode = 2'd1; adc_word = 16'h1357;
    @(negedge clk) continuous_en = 1'b1;
    wait_valid();
    check("R9", "first continuous result", {sample_result, sample_sub}, 16'h1357);
    adc_word = 16'hECA8;
    n = 1;
    while (adc_conv_n) begin
      @(negedge clk);
      if (adc_conv_n) n++;
    end
    check("R8", "settle gap cycles", n, ST);
    wait_valid();
    check("R9", "second continuous result", {sample_result, sample_sub}, 16'hECA8);
    continuous_en = 1'b0;
    while (busy) @(negedge clk);
    prev = conv_falls;
    repeat (100) @(negedge clk);
    check("R9", "strobes after continuous off", conv_falls - prev, 0);

    // R1: reset in the middle of a frame
    mdl_mode = 2'd2; sclk_mode = 2'd2; adc_word = 16'h0F0F;
    pulse_start();
    @(negedge adc_cs_n);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "outputs on mid-frame reset", {adc_conv_n, adc_cs_n, adc_sclk, busy, sample_valid}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "idle after mid-frame reset", busy, 0);

    summary();
    $finish;
  end
endmodule